// File: doc/BRIEF.md
# Transition Word Encoder for Low-Speed Data

This block turns a slow serial data level into one 8-bit code word per 125 µs frame, so that the data can travel in a single 64 kbps time-division channel in the same way as a voice sample. A slot tick splits each frame into 32 equal timeslots, and a frame strobe marks slot 0. On every tick the block samples the MARK/SPACE level and an optional violation flag. It records where level changes happen in the frame. After the tick of the last slot it reduces that record to one code word.

The word holds three things. The top bit is the data level in the last slot. A 2-bit frame-type field tells how many events the frame held and how far apart they were. A 5-bit position field gives the slot of the first event; in one frame type it instead packs the first slot together with a coarse position for the second event. The word is registered and comes with a one-cycle valid strobe. Putting the word onto the bus, converting the line format and generating the clocks are handled by other logic.

Top module: `twe_encoder`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `word_valid_o` is 0 and `word_o` is 8'h00.
- R2: A tick with `frame_strobe_i` high is slot 0, and each later tick is the next slot. The tick of slot 31 closes the frame. `word_valid_o` is high on the clock after that tick and for exactly one cycle.
- R3: Bit 7 of the word equals `data_i` sampled at the slot-31 tick.
- R4: An event occurs in slot k when `data_i` at that tick differs from its value at the previous tick. For slot 0, the previous tick is slot 31 of the previous frame. After reset, the previous level is taken as 0.
- R5: A frame with no event gives bits 6..5 = 2'b11 and bits 4..0 = 5'd31.
- R6: A frame with exactly one event gives bits 6..5 = 2'b10 and bits 4..0 = the slot of that event.
- R7: `viol_i` high at a tick counts as an event even though the level does not change. A frame whose only event is a violation is coded as in R6, and bit 7 keeps the level of the previous frame.
- R8: Two events whose slot gap is at most `SHORT_GAP_MAX` (default 19) give bits 6..5 = 2'b11 and bits 4..0 = the first slot.
- R9: Three or more events give bits 6..5 = 2'b11 and bits 4..0 = the first slot.
- R10: Two events whose gap exceeds `SHORT_GAP_MAX`, with the first in slot 4 or later, give bits 6..5 = 2'b01 and bits 4..0 = the first slot.
- R11: Two events whose gap exceeds `SHORT_GAP_MAX`, with the first in slots 0 to 3, give bits 6..5 = 2'b00. Bits 1..0 hold the first slot. Bits 4..2 hold the second slot minus `LONG_BASE` (default 24), clamped to the range 0..7.
- R12: A level change and a violation in the same slot count as one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick_i | input | 1 | One-cycle pulse per timeslot; samples the inputs |
| frame_strobe_i | input | 1 | High together with the tick of slot 0 |
| data_i | input | 1 | Current MARK/SPACE data level |
| viol_i | input | 1 | Violation pulse in this slot |
| word_o | output | 8 | Code word: level, frame type, position |
| word_valid_o | output | 1 | One-cycle strobe when `word_o` is new |

## Verification
The hardest cases to reach are those in which the code depends on spacing and history rather than on the count of events alone. Examples are a first event in slot 0 that can only be seen against the level at the end of the previous frame, a long-spaced pair whose second slot falls below the clamp base, and a violation that lands on the same slot as a real change. The stimulus keeps the line level running from frame to frame and builds each frame from chosen change slots and one violation slot, so that each of these situations can be placed deliberately. A behavioural model that keeps a list of event slots predicts every word.

// File: rtl/twe_pkg.sv
package twe_pkg;

    localparam int SLOTS       = 32;
    localparam int SLOT_W      = $clog2(SLOTS);
    localparam int EARLY_SLOTS = 4;
    localparam int SEC_W       = 3;

    typedef enum logic [1:0] {
        FT_LONG_EARLY = 2'b00,
        FT_LONG       = 2'b01,
        FT_SINGLE     = 2'b10,
        FT_SHORT      = 2'b11
    } ftype_e;

    typedef struct packed {
        logic [1:0]        n;
        logic [SLOT_W-1:0] s1;
        logic [SLOT_W-1:0] s2;
    } tally_t;

    typedef struct packed {
        logic              level;
        ftype_e            ftype;
        logic [SLOT_W-1:0] pos;
    } word_t;

    function automatic word_t classify(input tally_t t, input logic lvl,
                                       input logic [SLOT_W-1:0] short_max,
                                       input logic [SLOT_W-1:0] long_base);
        word_t w;
        logic [SLOT_W-1:0] gap;
        logic [SLOT_W-1:0] d;
        logic [SEC_W-1:0]  sec;
        w.level = lvl;
        gap = t.s2 - t.s1;
        d   = t.s2 - long_base;
        if (t.s2 < long_base)             sec = '0;
        else if (d > SLOT_W'((1 << SEC_W) - 1)) sec = '1;
        else                              sec = d[SEC_W-1:0];
        case (t.n)
            2'd0: begin w.ftype = FT_SHORT;  w.pos = '1;   end
            2'd1: begin w.ftype = FT_SINGLE; w.pos = t.s1; end
            2'd2: begin
                if (gap <= short_max) begin
                    w.ftype = FT_SHORT; w.pos = t.s1;
                end else if (t.s1 >= SLOT_W'(EARLY_SLOTS)) begin
                    w.ftype = FT_LONG; w.pos = t.s1;
                end else begin
                    w.ftype = FT_LONG_EARLY;
                    w.pos   = {sec, t.s1[1:0]};
                end
            end
            default: begin w.ftype = FT_SHORT; w.pos = t.s1; end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/twe_slot_track.sv
module twe_slot_track
    import twe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              frame_strobe_i,
    output logic [SLOT_W-1:0] idx_o,
    output logic              last_o
);
    logic [SLOT_W-1:0] cnt;

    assign idx_o  = frame_strobe_i ? '0 : cnt;
    assign last_o = tick_i && (idx_o == SLOT_W'(SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (tick_i) cnt <= idx_o + 1'b1;
    end

    AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (tick_i && frame_strobe_i) |=> (cnt == SLOT_W'(1))) else $error("slot restart"); // R2

endmodule

// File: rtl/twe_event_collect.sv
module twe_event_collect
    import twe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [SLOT_W-1:0] idx_i,
    input  logic              data_i,
    input  logic              viol_i,
    output tally_t            tally_o
);
    logic   prev;
    logic   ev;
    tally_t acc;
    tally_t base;
    tally_t upd;

    always_comb begin
        ev   = (data_i ^ prev) | viol_i;
        base = (idx_i == '0) ? '0 : acc;
        upd  = base;
        if (ev) begin
            case (base.n)
                2'd0:    begin upd.n = 2'd1; upd.s1 = idx_i; end
                2'd1:    begin upd.n = 2'd2; upd.s2 = idx_i; end
                default: upd.n = 2'd3;
            endcase
        end
    end

    assign tally_o = upd;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            prev <= 1'b0;
        end else if (tick_i) begin
            acc  <= upd;
            prev <= data_i;
        end
    end

    AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (rst)
        (acc.n >= 2'd2) |-> (acc.s2 > acc.s1)) else $error("slot order"); // R4

endmodule

// File: rtl/twe_classify.sv
module twe_classify
    import twe_pkg::*;
#(
    parameter int SHORT_GAP_MAX = 19,
    parameter int LONG_BASE     = 24
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   fin_i,
    input  tally_t tally_i,
    input  logic   level_i,
    output word_t  word_o,
    output logic   valid_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= fin_i;
            if (fin_i)
                word_o <= classify(tally_i, level_i,
                                   SLOT_W'(SHORT_GAP_MAX), SLOT_W'(LONG_BASE));
        end
    end

    AST_LONG_FIELD: assert property (@(posedge clk) disable iff (rst)
        (valid_o && word_o.ftype == FT_LONG) |-> (word_o.pos >= SLOT_W'(EARLY_SLOTS))) else $error("long field"); // R10

endmodule

// File: rtl/twe_encoder.sv
module twe_encoder
    import twe_pkg::*;
#(
    parameter int SHORT_GAP_MAX = 19,
    parameter int LONG_BASE     = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slot_tick_i,
    input  logic       frame_strobe_i,
    input  logic       data_i,
    input  logic       viol_i,
    output logic [7:0] word_o,
    output logic       word_valid_o
);
    logic [SLOT_W-1:0] idx;
    logic              last;
    tally_t            tally;
    word_t             word;

    twe_slot_track u_track (
        .clk(clk), .rst(rst), .tick_i(slot_tick_i), .frame_strobe_i(frame_strobe_i),
        .idx_o(idx), .last_o(last)
    );

    twe_event_collect u_collect (
        .clk(clk), .rst(rst), .tick_i(slot_tick_i), .idx_i(idx),
        .data_i(data_i), .viol_i(viol_i), .tally_o(tally)
    );

    twe_classify #(.SHORT_GAP_MAX(SHORT_GAP_MAX), .LONG_BASE(LONG_BASE)) u_class (
        .clk(clk), .rst(rst), .fin_i(last), .tally_i(tally), .level_i(data_i),
        .word_o(word), .valid_o(word_valid_o)
    );

    assign word_o = word;

    AST_LEVEL_BIT: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> (word_o[7] == $past(data_i))) else $error("level bit"); // R3
    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> $past(slot_tick_i)) else $error("valid w/o tick"); // R2
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |=> !word_valid_o) else $error("valid too long"); // R2

endmodule

// File: tb/sim_twe_encoder.sv
module sim_twe_encoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slot_tick_i = 1'b0;
    logic       frame_strobe_i = 1'b0;
    logic       data_i = 1'b0;
    logic       viol_i = 1'b0;
    logic [7:0] word_o;
    logic       word_valid_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic lvl = 1'b0;
    string cur_tag = "R5";

    // reference model state
    int    m_cnt = 0;
    logic  m_prev = 1'b0;
    int    m_ev[$];
    logic       ex_valid = 1'b0;
    logic [7:0] ex_word = 8'h00;
    string      ex_tag = "R5";

    always #2 clk = ~clk;

    twe_encoder u0 (
        .clk(clk), .rst(rst), .slot_tick_i(slot_tick_i), .frame_strobe_i(frame_strobe_i),
        .data_i(data_i), .viol_i(viol_i), .word_o(word_o), .word_valid_o(word_valid_o)
    );

    function automatic logic [7:0] expect_word(input logic lv);
        int n;
        int a;
        int b;
        int sec;
        n = m_ev.size();
        if (n == 0) return {lv, 2'b11, 5'd31};
        a = m_ev[0];
        if (n == 1) return {lv, 2'b10, 5'(a)};
        if (n >= 3) return {lv, 2'b11, 5'(a)};
        b = m_ev[1];
        if (b - a <= 19) return {lv, 2'b11, 5'(a)};
        if (a >= 4) return {lv, 2'b01, 5'(a)};
        sec = b - 24;
        if (sec < 0) sec = 0;
        if (sec > 7) sec = 7;
        return {lv, 2'b00, 3'(sec), 2'(a)};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_cnt = 0; m_prev = 1'b0; m_ev.delete();
            ex_valid = 1'b0; ex_word = 8'h00;
        end else begin
            ex_valid = 1'b0;
            if (slot_tick_i) begin
                int idx;
                idx = frame_strobe_i ? 0 : m_cnt;
                if (idx == 0) m_ev.delete();
                if ((data_i != m_prev) || viol_i) m_ev.push_back(idx);
                m_prev = data_i;
                m_cnt = (idx + 1) % 32;
                if (idx == 31) begin
                    ex_valid = 1'b1;
                    ex_word  = expect_word(data_i);
                    ex_tag   = cur_tag;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (word_valid_o !== ex_valid) begin
                errors++;
                $display("FAIL R2 valid: actual=%b expected=%b", word_valid_o, ex_valid);
            end
            if (ex_valid && word_valid_o) begin
                checks++;
                if (word_o[7] !== ex_word[7]) begin
                    errors++;
                    $display("FAIL R3 level bit: actual=%b expected=%b", word_o[7], ex_word[7]);
                end
                checks++;
                if (word_o[6:0] !== ex_word[6:0]) begin
                    errors++;
                    $display("FAIL %s code: actual=%h expected=%h", ex_tag, word_o, ex_word);
                end
            end
        end
    end

    task automatic run_frame(input int a, input int b, input int c, input int v, input string tag);
        cur_tag = tag;
        for (int s = 0; s < 32; s++) begin
            @(negedge clk);
            slot_tick_i = 1'b1;
            frame_strobe_i = (s == 0);
            if (s == a || s == b || s == c) lvl = ~lvl;
            data_i = lvl;
            viol_i = (s == v);
            @(negedge clk);
            slot_tick_i = 1'b0;
            frame_strobe_i = 1'b0;
            viol_i = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        checks++;
        if (word_valid_o !== 1'b0 || word_o !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset: actual=%b/%h expected=0/00", word_valid_o, word_o);
        end
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (word_valid_o !== 1'b0 || word_o !== 8'h00) begin
            errors++;
            $display("FAIL R1 after reset: actual=%b/%h expected=0/00", word_valid_o, word_o);
        end
        run_frame(-1, -1, -1, -1, "R5");
        run_frame(5, -1, -1, -1, "R6");
        run_frame(31, -1, -1, -1, "R6");
        run_frame(0, -1, -1, -1, "R4");
        run_frame(3, 16, -1, -1, "R8");
        run_frame(2, 15, 28, -1, "R9");
        run_frame(1, 9, 17, 25, "R9");
        run_frame(5, 31, -1, -1, "R10");
        run_frame(1, 27, -1, -1, "R11");
        run_frame(0, 21, -1, -1, "R11");
        run_frame(3, 30, -1, -1, "R11");
        run_frame(-1, -1, -1, 10, "R7");
        run_frame(7, -1, -1, 7, "R12");
        run_frame(-1, -1, -1, -1, "R5");
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        wait (cycles > 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
        finish_run();
    end
endmodule